// File: doc/BRIEF.md
# Serial Port Interrupt Cause and Status Word

This block collects the interrupt sources of one serial port into a single 32-bit status word that a host reads over its bus. It has five cause bits: line status error, receive data available, receive character timeout, transmit space available and modem status change. The same word also carries the modem lines, the line status flags and the 10-bit receive fill count. The shifters and FIFOs sit outside. They report to this block through single-cycle event pulses and steady levels.

Each cause is a sticky bit. It stays set until the host clears it by writing ones to it in the low byte. Several causes can be pending at once. Clearing the line status cause also clears the latched error flags. Clearing the modem cause also clears the latched delta flags.

Four enable bits come from a configuration register elsewhere. A small two-state machine turns the enabled, pending causes into a registered level interrupt. Its states are `IRQ_IDLE` (no enabled cause pending, output low) and `IRQ_RAISED` (output high). It has two transitions:
- raise: `IRQ_IDLE` to `IRQ_RAISED` when an enabled cause is pending.
- drop: `IRQ_RAISED` to `IRQ_IDLE` when none is pending.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, all cause bits, delta flags and latched error flags are 0 and `irq_o` is low. With every input at 0, `status_o` reads 0.
- R2: A one-cycle event pulse sets its cause bit at the next clock edge. The cause bit positions are: `status_o[0]` line status, `[1]` receive available, `[2]` character timeout, `[3]` transmit space, `[4]` modem change. Several cause bits may be set together.
- R3: When `clr_wr_i` is high, each cause bit whose `clr_data_i` bit is 1 is cleared at the next edge. Cause bits whose `clr_data_i` bit is 0 are kept. When `clr_wr_i` is low, `clr_data_i` has no effect.
- R4: If an event pulse for a cause arrives in the same cycle as a write that clears that cause, the cause bit stays set.
- R5: `status_o[7:6]` equal `rx_fill_i[9:8]` and `status_o[31:24]` equal `rx_fill_i[7:0]`. They follow the input in the same cycle, and clearing writes do not affect them.
- R6: `status_o[15:12]` show CTS, DSR, RI and DCD, in that order, as sampled at the previous edge. Delta flags `status_o[8]` (CTS), `[9]` (DSR) and `[11]` (DCD) latch on any change of their line. `status_o[10]` latches only on a 1-to-0 change of RI. Any flag latching sets cause bit 4.
- R7: Clearing cause bit 4 clears all four delta flags. Clearing any other cause bit leaves them unchanged.
- R8: `status_o[16]`, `[21]` and `[22]` pass through receive-ready, holding-empty and transmitter-idle directly. Error pulses latch sticky flags: overrun `[17]`, parity `[18]`, framing `[19]`, break `[20]` and receive FIFO error `[23]`. Each error also sets cause bit 0. Clearing cause bit 0 clears all five error flags, and clearing any other cause bit does not.
- R9: Enable mapping: `irq_en_i[0]` gates cause bits 1 and 2, `[1]` gates bit 3, `[2]` gates bit 0, and `[3]` gates bit 4. `irq_o` goes high one edge after an enabled cause becomes pending, and goes low one edge after none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_wr_i | input | 1 | Host write to byte 0 of the status word |
| clr_data_i | input | 5 | Cause field of that write; ones clear |
| irq_en_i | input | 4 | Cause enables from the configuration register |
| rx_avail_i | input | 1 | Pulse: receive data above threshold |
| rx_timeout_i | input | 1 | Pulse: receive character timeout |
| tx_space_i | input | 1 | Pulse: transmit space above threshold |
| err_overrun_i | input | 1 | Pulse: overrun |
| err_parity_i | input | 1 | Pulse: parity error |
| err_frame_i | input | 1 | Pulse: framing error |
| err_break_i | input | 1 | Pulse: break received |
| err_rxfifo_i | input | 1 | Pulse: error inside the receive FIFO |
| rx_ready_i | input | 1 | Level: receive data present |
| thr_empty_i | input | 1 | Level: transmit holding empty |
| tx_idle_i | input | 1 | Level: transmitter fully idle |
| cts_i | input | 1 | Modem line CTS |
| dsr_i | input | 1 | Modem line DSR |
| ri_i | input | 1 | Modem line RI |
| dcd_i | input | 1 | Modem line DCD |
| rx_fill_i | input | 10 | Receive FIFO fill count |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an event landing in the same cycle as the write that clears its cause. The bench drives the event pulse and the clearing write in one cycle, then reads back that the bit survived.

The ring line is the next hardest. Its flag must ignore the leading edge and latch on the trailing one. The bench raises RI, checks that the flag stays 0, then lowers RI.

The bench also sweeps every cause against all sixteen enable masks. Each step clears, pulses and checks both the status bit and the interrupt level.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int CAUSE_N  = 5;
    localparam int EN_N     = 4;
    localparam int MODEM_N  = 4;
    localparam int ERR_N    = 5;
    localparam int FILL_W   = 10;
    localparam int FILL_LO  = 8;
    localparam int FILL_HI  = FILL_W - FILL_LO;

    // cause bit positions (host decodes these)
    localparam int C_LINE  = 0;
    localparam int C_RXAV  = 1;
    localparam int C_RXTO  = 2;
    localparam int C_TXSP  = 3;
    localparam int C_MODEM = 4;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    // modem line order
    localparam int M_RI = 2;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic logic [CAUSE_N-1:0] cause_gate(input logic [EN_N-1:0] en);
        logic [CAUSE_N-1:0] g;
        g          = '0;
        g[C_LINE]  = en[EN_LINE];
        g[C_RXAV]  = en[EN_RX];
        g[C_RXTO]  = en[EN_RX];
        g[C_TXSP]  = en[EN_TX];
        g[C_MODEM] = en[EN_MODEM];
        return g;
    endfunction
endpackage

// File: rtl/uirq_sticky_bank.sv
module uirq_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;          // a new event beats a clear
            else if (clr_i[i])
                q <= 1'b0;
        end
        assign q_o[i] = q;
    end
endmodule

// File: rtl/uirq_modem_track.sv
module uirq_modem_track
    import uirq_pkg::*;
#(
    parameter int W = MODEM_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic         clr_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] delta_o,
    output logic         event_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= line_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        if (i == M_RI) begin : g_trail
            assign change[i] = prev_q[i] & ~line_i[i];
        end else begin : g_any
            assign change[i] = prev_q[i] ^ line_i[i];
        end
    end

    uirq_sticky_bank #(.N(W)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (change),
        .clr_i ({W{clr_i}}),
        .q_o   (delta_o)
    );

    assign cur_o   = prev_q;
    assign event_o = |change;
endmodule

// File: rtl/uirq_irq_fsm.sv
module uirq_irq_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending_i)  state_d = IRQ_RAISED;   // raise
            IRQ_RAISED: if (!pending_i) state_d = IRQ_IDLE;     // drop
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_wr_i,
    input  logic [CAUSE_N-1:0] clr_data_i,
    input  logic [EN_N-1:0]    irq_en_i,
    input  logic               rx_avail_i,
    input  logic               rx_timeout_i,
    input  logic               tx_space_i,
    input  logic               err_overrun_i,
    input  logic               err_parity_i,
    input  logic               err_frame_i,
    input  logic               err_break_i,
    input  logic               err_rxfifo_i,
    input  logic               rx_ready_i,
    input  logic               thr_empty_i,
    input  logic               tx_idle_i,
    input  logic               cts_i,
    input  logic               dsr_i,
    input  logic               ri_i,
    input  logic               dcd_i,
    input  logic [FILL_W-1:0]  rx_fill_i,
    output logic [31:0]        status_o,
    output logic               irq_o
);
    logic [CAUSE_N-1:0] clr_vec;
    logic [CAUSE_N-1:0] set_vec;
    logic [CAUSE_N-1:0] cause_q;
    logic [ERR_N-1:0]   err_pulse;
    logic [ERR_N-1:0]   err_q;
    logic [MODEM_N-1:0] modem_cur;
    logic [MODEM_N-1:0] modem_delta;
    logic               modem_evt;
    logic               pending;

    assign clr_vec   = clr_wr_i ? clr_data_i : '0;
    assign err_pulse = {err_rxfifo_i, err_break_i, err_frame_i, err_parity_i, err_overrun_i};

    always_comb begin
        set_vec          = '0;
        set_vec[C_LINE]  = |err_pulse;
        set_vec[C_RXAV]  = rx_avail_i;
        set_vec[C_RXTO]  = rx_timeout_i;
        set_vec[C_TXSP]  = tx_space_i;
        set_vec[C_MODEM] = modem_evt;
    end

    uirq_sticky_bank #(.N(CAUSE_N)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (cause_q)
    );

    uirq_sticky_bank #(.N(ERR_N)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_pulse),
        .clr_i ({ERR_N{clr_vec[C_LINE]}}),
        .q_o   (err_q)
    );

    uirq_modem_track #(.W(MODEM_N)) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  ({dcd_i, ri_i, dsr_i, cts_i}),
        .clr_i   (clr_vec[C_MODEM]),
        .cur_o   (modem_cur),
        .delta_o (modem_delta),
        .event_o (modem_evt)
    );

    assign pending = |(cause_q & cause_gate(irq_en_i));

    uirq_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        status_o        = '0;
        status_o[4:0]   = cause_q;
        status_o[7:6]   = rx_fill_i[FILL_W-1:FILL_LO];
        status_o[11:8]  = modem_delta;
        status_o[15:12] = modem_cur;
        status_o[23:16] = {err_q[4], tx_idle_i, thr_empty_i, err_q[3:0], rx_ready_i};
        status_o[31:24] = rx_fill_i[FILL_LO-1:0];
    end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
    import uirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               clr_wr_i,
    input logic [CAUSE_N-1:0] clr_data_i,
    input logic [EN_N-1:0]    irq_en_i,
    input logic               rx_avail_i,
    input logic               tx_space_i,
    input logic               err_overrun_i,
    input logic               cts_i,
    input logic [FILL_W-1:0]  rx_fill_i,
    input logic [31:0]        status_o,
    input logic               irq_o
);
    logic pend;
    assign pend = |(status_o[4:0] & cause_gate(irq_en_i));

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail_i |=> status_o[1]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[1] && !rx_avail_i) |=> !status_o[1]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_space_i && clr_wr_i && clr_data_i[3]) |=> status_o[3]);

    assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[31:24] == rx_fill_i[7:0]) && (status_o[7:6] == rx_fill_i[9:8]));

    assert_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[12] == $past(cts_i)));

    assert_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun_i |=> (status_o[17] && status_o[0]));

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(pend)));
endmodule

bind uart_irq_status uirq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_wr_i      (clr_wr_i),
    .clr_data_i    (clr_data_i),
    .irq_en_i      (irq_en_i),
    .rx_avail_i    (rx_avail_i),
    .tx_space_i    (tx_space_i),
    .err_overrun_i (err_overrun_i),
    .cts_i         (cts_i),
    .rx_fill_i     (rx_fill_i),
    .status_o      (status_o),
    .irq_o         (irq_o)
);

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_wr_i = 1'b0;
    logic [4:0]  clr_data_i = '0;
    logic [3:0]  irq_en_i = '0;
    logic        rx_avail_i = 0, rx_timeout_i = 0, tx_space_i = 0;
    logic        err_overrun_i = 0, err_parity_i = 0, err_frame_i = 0;
    logic        err_break_i = 0, err_rxfifo_i = 0;
    logic        rx_ready_i = 0, thr_empty_i = 0, tx_idle_i = 0;
    logic        cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic [9:0]  rx_fill_i = '0;
    logic [31:0] status_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uart_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .irq_en_i(irq_en_i), .rx_avail_i(rx_avail_i), .rx_timeout_i(rx_timeout_i),
        .tx_space_i(tx_space_i), .err_overrun_i(err_overrun_i),
        .err_parity_i(err_parity_i), .err_frame_i(err_frame_i),
        .err_break_i(err_break_i), .err_rxfifo_i(err_rxfifo_i),
        .rx_ready_i(rx_ready_i), .thr_empty_i(thr_empty_i), .tx_idle_i(tx_idle_i),
        .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
        .rx_fill_i(rx_fill_i), .status_o(status_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_write(input logic [4:0] d);
        clr_wr_i = 1'b1; clr_data_i = d;
        tick();
        clr_wr_i = 1'b0; clr_data_i = '0;
    endtask

    function automatic logic gate_of(input int c, input logic [3:0] m);
        case (c)
            0:       return m[2];
            1, 2:    return m[0];
            3:       return m[1];
            default: return m[3];
        endcase
    endfunction

    task automatic pulse_err(input int k);
        case (k)
            0: err_overrun_i = 1;
            1: err_parity_i  = 1;
            2: err_frame_i   = 1;
            3: err_break_i   = 1;
            default: err_rxfifo_i = 1;
        endcase
        tick();
        err_overrun_i = 0; err_parity_i = 0; err_frame_i = 0;
        err_break_i = 0; err_rxfifo_i = 0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 status", status_o, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2/R9/R3 sweep: every cause against every enable mask
        for (int c = 0; c < 5; c++) begin
            for (int m = 0; m < 16; m++) begin
                irq_en_i = m[3:0];
                clear_write(5'h1F);
                tick();
                case (c)
                    0: pulse_err(m % 5);
                    1: begin rx_avail_i = 1; tick(); rx_avail_i = 0; end
                    2: begin rx_timeout_i = 1; tick(); rx_timeout_i = 0; end
                    3: begin tx_space_i = 1; tick(); tx_space_i = 0; end
                    default: begin cts_i = ~cts_i; tick(); end
                endcase
                check("R2 cause set", {31'b0, status_o[c]}, 32'h1);
                if (c == 0) begin
                    int pos;
                    pos = ((m % 5) < 4) ? 17 + (m % 5) : 23;
                    check("R8 error flag", {31'b0, status_o[pos]}, 32'h1);
                end
                if (c == 4)
                    check("R6 delta cts", {31'b0, status_o[8]}, 32'h1);
                tick();
                check("R9 irq gate", {31'b0, irq_o}, {31'b0, gate_of(c, m[3:0])});
                // write data presented without the strobe: no effect
                clr_data_i = 5'h1F;
                tick();
                clr_data_i = '0;
                check("R3 no strobe", {31'b0, status_o[c]}, 32'h1);
                clear_write(5'h1F);
                check("R3 cleared", {27'b0, status_o[4:0]}, 32'h0);
                tick();
                check("R9 irq drop", {31'b0, irq_o}, 32'h0);
            end
        end
        irq_en_i = '0;

        // R2/R3 multiple causes, selective clear
        rx_avail_i = 1; tx_space_i = 1; tick(); rx_avail_i = 0; tx_space_i = 0;
        check("R2 two causes", {27'b0, status_o[4:0]}, 32'h0A);
        clear_write(5'h02);
        check("R3 selective clear", {27'b0, status_o[4:0]}, 32'h08);

        // R4 event coinciding with clear
        tx_space_i = 1; clr_wr_i = 1; clr_data_i = 5'h08;
        tick();
        tx_space_i = 0; clr_wr_i = 0; clr_data_i = '0;
        check("R4 set beats clear", {31'b0, status_o[3]}, 32'h1);
        rx_timeout_i = 1; clr_wr_i = 1; clr_data_i = 5'h1F;
        tick();
        rx_timeout_i = 0; clr_wr_i = 0; clr_data_i = '0;
        check("R4 other bits clear", {27'b0, status_o[4:0]}, 32'h04);
        clear_write(5'h1F);

        // R5 fill count sweep
        for (int f = 0; f < 1024; f += 31) begin
            rx_fill_i = f[9:0];
            #1;
            check("R5 fill low", {24'b0, status_o[31:24]}, f & 32'hFF);
            check("R5 fill high", {30'b0, status_o[7:6]}, (f >> 8) & 3);
        end
        rx_fill_i = 10'h3FF;
        clear_write(5'h1F);
        check("R5 fill after write", {30'b0, status_o[7:6]}, 32'h3);
        rx_fill_i = '0;

        // R6 modem: current sampling, RI edges, DSR/DCD deltas
        clear_write(5'h1F);
        cts_i = 0;
        tick(); clear_write(5'h1F);
        ri_i = 1; tick();
        check("R6 ri lead no flag", {28'b0, status_o[11:8]}, 32'h0);
        check("R6 ri current", {31'b0, status_o[14]}, 32'h1);
        check("R6 no cause on lead", {31'b0, status_o[4]}, 32'h0);
        ri_i = 0; tick();
        check("R6 ri trail flag", {28'b0, status_o[11:8]}, 32'h4);
        dsr_i = 1; dcd_i = 1; tick();
        check("R6 dsr dcd flags", {28'b0, status_o[11:8]}, 32'hE);
        check("R6 current lines", {28'b0, status_o[15:12]}, 32'hA);
        check("R6 modem cause", {31'b0, status_o[4]}, 32'h1);
        // R7 other clears keep deltas, modem clear wipes them
        clear_write(5'h0F);
        check("R7 deltas kept", {28'b0, status_o[11:8]}, 32'hE);
        clear_write(5'h10);
        check("R7 deltas cleared", {28'b0, status_o[11:8]}, 32'h0);
        dsr_i = 0; dcd_i = 0; tick(); clear_write(5'h1F);

        // R8 pass-through levels and error flag clearing
        rx_ready_i = 1; thr_empty_i = 1; tx_idle_i = 1;
        #1;
        check("R8 levels", {24'b0, status_o[23:16]}, 32'h61);
        rx_ready_i = 0; thr_empty_i = 0; tx_idle_i = 0;
        for (int k = 0; k < 5; k++) pulse_err(k);
        check("R8 all errors", {24'b0, status_o[23:16]}, 32'h9E);
        clear_write(5'h1E);
        check("R8 errors kept", {24'b0, status_o[23:16]}, 32'h9E);
        clear_write(5'h01);
        check("R8 errors cleared", {24'b0, status_o[23:16]}, 32'h00);
        check("R8 cause cleared", {31'b0, status_o[0]}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule